// File: doc/BRIEF.md
# TDM Time-Slot Assigner with Shadow Table

The block steps through a table of 16-bit routing entries once per TDM frame, advancing one bit per clock, so that a multichannel serial controller knows which logical channel owns each serial bit. The transmit and receive directions have their own tables and their own walkers. Each entry describes one slot: its channel number, its length in bits or in bytes, whether the slot is active, whether receive data is looped back from the transmit line, and whether the entry closes the frame.

A host write port fills either table. Two regions of each table can be used: a main region and a shadow region, each starting on a 32-entry bank boundary. A request to swap regions is honoured only at a frame sync, so software can rewrite the idle region while the other one is in use. Frame sync is detected on its transition to the active level (polarity selectable), then delayed by 0 to 3 clocks separately for each direction before the walk starts.

Each walker is a three-state machine. `W_IDLE` (after reset) moves to `W_RUN` on a start pulse. In `W_RUN` a slot's bits are counted down; at the last bit of a slot the next entry is loaded (stay in `W_RUN`), or, if the slot carried the last-entry flag, the walker moves to `W_WAIT`. A start pulse in `W_RUN` restarts the walk at the table base (overrun if the current bit was not the final bit of the final entry). `W_WAIT` moves back to `W_RUN` on the next start pulse.

Top module: `tdm_slot_assigner`

## Requirements
- R1: An entry is laid out as bit 15 enable, bit 14 loop, bit 13 super-channel, bits 12..5 channel, bits 4..2 count, bit 1 byte resolution, bit 0 last; during a slot the channel output shows bits 12..5 and the super output shows bit 13.
- R2: A slot lasts count+1 bits when byte resolution is 0 and 8*(count+1) bits when it is 1, with no gap between consecutive slots.
- R3: After the final bit of an entry with the last flag set, valid stays low until the next start; every start begins the walk at the table base with a first strobe.
- R4: A host write with host_rx_sel=0 goes only to the transmit table and with host_rx_sel=1 only to the receive table.
- R5: The table base is 32*main_bank, or 32*shadow_bank while the shadow region is active; shadow_req is copied into shadow_active only at a detected frame sync, and that sync already uses the new region.
- R6: During a receive slot whose loop bit is 1, rx_bit equals txd, otherwise rx_bit equals rxd; tx_echo is high during a transmit slot whose loop bit is 1.
- R7: The first bit of a frame appears 2+D clocks after the edge at which active fsync is first sampled, D being tx_fs_dly or rx_fs_dly for that direction.
- R8: With sync_inv=0 fsync is active high, with sync_inv=1 active low; only a change from inactive to active starts a frame.
- R9: A slot whose enable bit is 0 keeps valid and first low for all of its bits while still taking its full length.
- R10: A start arriving while a walk is still in progress (other than on the final bit) restarts the walk at the base and pulses that direction's overrun output high for the first bit of the restarted walk.
- R11: After reset, valid, first, overrun and shadow_active outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync |
| rxd | input | 1 | Serial receive data pin |
| txd | input | 1 | Serial transmit data from the controller, used for loopback |
| sync_inv | input | 1 | 1 makes fsync active low |
| tx_fs_dly | input | 2 | Transmit frame-sync delay in clocks |
| rx_fs_dly | input | 2 | Receive frame-sync delay in clocks |
| main_bank | input | 3 | Main region start, in 32-entry banks |
| shadow_bank | input | 3 | Shadow region start, in 32-entry banks |
| shadow_req | input | 1 | Requested region, 1 = shadow |
| host_we | input | 1 | Table write strobe |
| host_rx_sel | input | 1 | 0 writes transmit table, 1 writes receive table |
| host_addr | input | ADDR_W | Table write address |
| host_data | input | 16 | Entry to write |
| tx_chan | output | 8 | Channel of the current transmit bit |
| tx_valid | output | 1 | Current transmit bit belongs to an enabled slot |
| tx_first | output | 1 | Current transmit bit is the first of an enabled slot |
| tx_super | output | 1 | Current transmit slot is part of a super-channel |
| tx_echo | output | 1 | Current transmit slot has its loop bit set |
| tx_overrun | output | 1 | Transmit walk was restarted early |
| rx_chan | output | 8 | Channel of the current receive bit |
| rx_valid | output | 1 | Current receive bit belongs to an enabled slot |
| rx_first | output | 1 | Current receive bit is the first of an enabled slot |
| rx_super | output | 1 | Current receive slot is part of a super-channel |
| rx_bit | output | 1 | Receive bit after loopback selection |
| rx_overrun | output | 1 | Receive walk was restarted early |
| shadow_active | output | 1 | 1 while the shadow region is in use |

## Verification
The walk is exercised with tables mixing one-bit, multi-bit and byte-resolution slots, so a wrong length or an inserted gap shifts every later channel number and is caught bit by bit. A disabled slot placed ahead of an enabled one separates "slot skipped" from "slot silenced", and differing transmit and receive contents at the same base separate the two tables. Frames are also started with each delay value, with inverted polarity, from a non-zero main bank and from the shadow bank before and after a swap request, which tells apart a base or region chosen at the wrong moment. A second sync injected mid-slot distinguishes a clean restart with an overrun pulse from a walk that ignores the early sync.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int NDIR  = 2;     // index 0 transmit, index 1 receive
    localparam int CH_W  = 8;
    localparam int CNT_W = 6;     // up to 64 bits per slot

    typedef struct packed {
        logic            en;
        logic            loop;
        logic            super_ch;
        logic [CH_W-1:0] chan;
        logic [2:0]      cnt;
        logic            byte_res;
        logic            last;
    } tsa_entry_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_RUN  = 2'd1,
        W_WAIT = 2'd2
    } walk_state_t;

    // slot length minus one, in bits
    function automatic logic [CNT_W-1:0] slot_len_m1(input tsa_entry_t e);
        if (e.byte_res) begin
            return {e.cnt, 3'b111};
        end
        return {3'b000, e.cnt};
    endfunction

endpackage

// File: rtl/tsa_table.sv
module tsa_table #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [15:0]       wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [15:0]       rdata_o
);

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/tsa_sync.sv
module tsa_sync
    import tsa_pkg::*;
#(
    parameter int DLY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fsync_i,
    input  logic                       inv_i,
    input  logic [NDIR-1:0][DLY_W-1:0] dly_i,
    output logic                       evt_o,
    output logic [NDIR-1:0]            start_o
);

    localparam int MAX_DLY = (1 << DLY_W) - 1;

    logic               fs_q;
    logic               fs_q2;
    logic [MAX_DLY:1]   evt_sr;
    logic [MAX_DLY:0]   taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            fs_q2  <= 1'b0;
            evt_sr <= '0;
        end else begin
            fs_q   <= fsync_i ^ inv_i;
            fs_q2  <= fs_q;
            evt_sr <= {taps[MAX_DLY-1:0]};
        end
    end

    // detected transition to the active level
    assign evt_o = fs_q & ~fs_q2;
    assign taps  = {evt_sr, evt_o};

    for (genvar g = 0; g < NDIR; g++) begin : g_tap
        assign start_o[g] = taps[dly_i[g]];
    end

endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
    import tsa_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  tsa_entry_t        rd_ent_i,
    output logic              valid_o,
    output logic              first_o,
    output logic              loop_o,
    output logic              super_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              overrun_o
);

    walk_state_t       state_q;
    walk_state_t       state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              en_q;
    logic              loop_q;
    logic              sup_q;
    logic              last_q;
    logic [CH_W-1:0]   ch_q;
    logic              first_q;
    logic              ovr_q;
    logic              load;
    logic              slot_end;
    logic              active;

    assign slot_end  = (cnt_q == '0);
    assign rd_addr_o = start_i ? base_i : ptr_q;

    // next-state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            W_IDLE, W_WAIT: begin
                if (start_i) begin
                    state_d = W_RUN;
                    load    = 1'b1;
                end
            end
            W_RUN: begin
                if (start_i) begin
                    load = 1'b1;
                end else if (slot_end) begin
                    if (last_q) begin
                        state_d = W_WAIT;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // slot datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            cnt_q   <= '0;
            en_q    <= 1'b0;
            loop_q  <= 1'b0;
            sup_q   <= 1'b0;
            last_q  <= 1'b0;
            ch_q    <= '0;
            first_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            ovr_q <= start_i && (state_q == W_RUN) && !(slot_end && last_q);
            if (load) begin
                ptr_q   <= rd_addr_o + 1'b1;
                cnt_q   <= slot_len_m1(rd_ent_i);
                en_q    <= rd_ent_i.en;
                loop_q  <= rd_ent_i.loop;
                sup_q   <= rd_ent_i.super_ch;
                last_q  <= rd_ent_i.last;
                ch_q    <= rd_ent_i.chan;
                first_q <= 1'b1;
            end else if (state_q == W_RUN && !slot_end) begin
                cnt_q   <= cnt_q - 1'b1;
                first_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        active    = (state_q == W_RUN);
        valid_o   = active & en_q;
        first_o   = active & en_q & first_q;
        loop_o    = active & loop_q;
        super_o   = active & sup_q;
        ch_o      = ch_q;
        overrun_o = ovr_q;
    end

    // R2: inside a slot the entry is held and the counter steps down by one
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_RUN && !start_i && !slot_end)
        |=> (state_q == W_RUN && $stable(ch_q) && $stable(en_q)
             && cnt_q == $past(cnt_q) - 1'b1));

    // R3: a finished walk stays silent until the next start
    p_wait_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_WAIT && !start_i) |=> !valid_o);

    // R3: every start resumes at the base entry
    p_restart_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == W_RUN && first_q && ptr_q == $past(base_i) + 1'b1));

    // R10: overrun only reports a walk that was already running
    p_overrun_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> (state_q == W_RUN && first_q && $past(state_q) == W_RUN));

endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
    import tsa_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANK_SIZE = 32,
    parameter int DLY_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              rxd,
    input  logic              txd,
    input  logic              sync_inv,
    input  logic [DLY_W-1:0]  tx_fs_dly,
    input  logic [DLY_W-1:0]  rx_fs_dly,
    input  logic [2:0]        main_bank,
    input  logic [2:0]        shadow_bank,
    input  logic              shadow_req,
    input  logic              host_we,
    input  logic              host_rx_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_data,
    output logic [CH_W-1:0]   tx_chan,
    output logic              tx_valid,
    output logic              tx_first,
    output logic              tx_super,
    output logic              tx_echo,
    output logic              tx_overrun,
    output logic [CH_W-1:0]   rx_chan,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              rx_super,
    output logic              rx_bit,
    output logic              rx_overrun,
    output logic              shadow_active
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BANK_SHIFT = $clog2(BANK_SIZE);

    logic                       sync_evt;
    logic [NDIR-1:0]            start;
    logic [NDIR-1:0][DLY_W-1:0] dly;
    logic                       shadow_q;
    logic                       region_now;
    logic [2:0]                 bank_now;
    logic [ADDR_W-1:0]          base;
    logic [ADDR_W-1:0]          rd_addr [NDIR];
    logic [15:0]                rd_word [NDIR];
    logic [NDIR-1:0]            valid;
    logic [NDIR-1:0]            first;
    logic [NDIR-1:0]            loop;
    logic [NDIR-1:0]            sup;
    logic [NDIR-1:0]            ovr;
    logic [NDIR-1:0][CH_W-1:0]  chan;

    assign dly = {rx_fs_dly, tx_fs_dly};

    tsa_sync #(.DLY_W(DLY_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync),
        .inv_i   (sync_inv),
        .dly_i   (dly),
        .evt_o   (sync_evt),
        .start_o (start)
    );

    // region swap is taken only at a detected frame sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
        end else if (sync_evt) begin
            shadow_q <= shadow_req;
        end
    end

    assign region_now = sync_evt ? shadow_req : shadow_q;
    assign bank_now   = region_now ? shadow_bank : main_bank;
    assign base       = ADDR_W'(int'(bank_now) << BANK_SHIFT);

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        tsa_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_tbl (
            .clk     (clk),
            .we_i    (host_we && (host_rx_sel == 1'(g))),
            .waddr_i (host_addr),
            .wdata_i (host_data),
            .raddr_i (rd_addr[g]),
            .rdata_o (rd_word[g])
        );

        tsa_walker #(.ADDR_W(ADDR_W)) u_walk (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start[g]),
            .base_i    (base),
            .rd_addr_o (rd_addr[g]),
            .rd_ent_i  (tsa_entry_t'(rd_word[g])),
            .valid_o   (valid[g]),
            .first_o   (first[g]),
            .loop_o    (loop[g]),
            .super_o   (sup[g]),
            .ch_o      (chan[g]),
            .overrun_o (ovr[g])
        );
    end

    assign tx_chan       = chan[0];
    assign tx_valid      = valid[0];
    assign tx_first      = first[0];
    assign tx_super      = sup[0];
    assign tx_echo       = loop[0];
    assign tx_overrun    = ovr[0];
    assign rx_chan       = chan[1];
    assign rx_valid      = valid[1];
    assign rx_first      = first[1];
    assign rx_super      = sup[1];
    assign rx_overrun    = ovr[1];
    assign rx_bit        = loop[1] ? txd : rxd;
    assign shadow_active = shadow_q;

    // R5: the visible region changes only right after a detected sync
    p_shadow_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_q) |-> $past(sync_evt));

endmodule

// File: tb/tdm_slot_assigner_tb.sv
module tdm_slot_assigner_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          rxd = 1'b0;
    logic          txd = 1'b1;
    logic          sync_inv = 1'b0;
    logic [1:0]    tx_fs_dly = 2'd0;
    logic [1:0]    rx_fs_dly = 2'd0;
    logic [2:0]    main_bank = 3'd0;
    logic [2:0]    shadow_bank = 3'd0;
    logic          shadow_req = 1'b0;
    logic          host_we = 1'b0;
    logic          host_rx_sel = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_data = '0;
    logic [7:0]    tx_chan, rx_chan;
    logic          tx_valid, tx_first, tx_super, tx_echo, tx_overrun;
    logic          rx_valid, rx_first, rx_super, rx_bit, rx_overrun;
    logic          shadow_active;

    tdm_slot_assigner u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .txd(txd),
        .sync_inv(sync_inv), .tx_fs_dly(tx_fs_dly), .rx_fs_dly(rx_fs_dly),
        .main_bank(main_bank), .shadow_bank(shadow_bank), .shadow_req(shadow_req),
        .host_we(host_we), .host_rx_sel(host_rx_sel), .host_addr(host_addr),
        .host_data(host_data),
        .tx_chan(tx_chan), .tx_valid(tx_valid), .tx_first(tx_first),
        .tx_super(tx_super), .tx_echo(tx_echo), .tx_overrun(tx_overrun),
        .rx_chan(rx_chan), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_super(rx_super), .rx_bit(rx_bit), .rx_overrun(rx_overrun),
        .shadow_active(shadow_active)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] img [2][256];
    int exp_ch [1024];
    bit exp_v [1024];
    bit exp_f [1024];
    bit exp_lp [1024];
    bit exp_sp [1024];
    int n_exp;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit en, input bit lp, input bit sp,
                                       input int ch, input int cnt, input bit br,
                                       input bit last);
        return {en, lp, sp, 8'(ch), 3'(cnt), br, last};
    endfunction

    task automatic wr(input int dir, input int addr, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_rx_sel = 1'(dir);
        host_addr = AW'(addr);
        host_data = d;
        img[dir][addr] = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // expected bit sequence from the entry layout of R1 and the lengths of R2
    task automatic build(input int dir, input int base);
        int a;
        n_exp = 0;
        a = base;
        for (int e = 0; e < 64; e++) begin
            logic [15:0] w;
            int len;
            w = img[dir][a];
            len = w[1] ? (int'(w[4:2]) + 1) * 8 : int'(w[4:2]) + 1;
            for (int b = 0; b < len; b++) begin
                exp_v[n_exp]  = w[15];
                exp_f[n_exp]  = w[15] && (b == 0);
                exp_ch[n_exp] = int'(w[12:5]);
                exp_lp[n_exp] = w[14];
                exp_sp[n_exp] = w[13];
                n_exp++;
            end
            if (w[0]) break;
            a = (a + 1) % 256;
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        fsync = ~sync_inv;
        @(negedge clk);
        fsync = sync_inv;
    endtask

    // one frame; first bit sampled 2+dly clocks after the sync sample edge (R7)
    task automatic frame(input int dir, input int base, input int dly, input string tag);
        build(dir, base);
        pulse_sync();
        repeat (1 + dly) @(negedge clk);
        for (int i = 0; i < n_exp; i++) begin
            chk(tag, "valid", dir ? rx_valid : tx_valid, exp_v[i]);
            chk(tag, "first", dir ? rx_first : tx_first, exp_f[i]);
            chk(tag, "super", dir ? rx_super : tx_super, exp_sp[i]);
            if (exp_v[i]) chk(tag, "chan", dir ? rx_chan : tx_chan, exp_ch[i]);
            if (dir == 1) chk(tag, "rx_bit", rx_bit, exp_lp[i]);
            else          chk(tag, "tx_echo", tx_echo, exp_lp[i]);
            @(negedge clk);
        end
        repeat (4) begin
            chk("R3", "idle valid", dir ? rx_valid : tx_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R11", "tx_valid", tx_valid, 0);
        chk("R11", "rx_valid", rx_valid, 0);
        chk("R11", "first", tx_first | rx_first, 0);
        chk("R11", "overrun", tx_overrun | rx_overrun, 0);
        chk("R11", "shadow_active", shadow_active, 0);
    endtask

    task automatic t_basic();
        wr(0, 0, mk(1, 0, 0, 3, 2, 0, 0));
        wr(0, 1, mk(1, 0, 1, 7, 0, 1, 0));
        wr(0, 2, mk(1, 0, 0, 200, 0, 0, 1));
        frame(0, 0, 0, "R1/R2");
        frame(0, 0, 0, "R3");
    endtask

    task automatic t_rx_indep();
        wr(1, 0, mk(0, 0, 0, 9, 3, 0, 0));
        wr(1, 1, mk(1, 0, 0, 17, 1, 1, 1));
        frame(1, 0, 0, "R4/R9");
        frame(0, 0, 0, "R4");
    endtask

    task automatic t_loop();
        wr(1, 0, mk(1, 1, 0, 4, 1, 0, 0));
        wr(1, 1, mk(1, 0, 0, 5, 1, 0, 0));
        wr(1, 2, mk(1, 1, 0, 6, 0, 0, 1));
        wr(0, 0, mk(1, 1, 0, 8, 1, 0, 1));
        frame(1, 0, 0, "R6");
        frame(0, 0, 0, "R6");
    endtask

    task automatic t_delay();
        @(negedge clk);
        tx_fs_dly = 2'd2;
        rx_fs_dly = 2'd3;
        frame(0, 0, 2, "R7");
        frame(1, 0, 3, "R7");
        @(negedge clk);
        tx_fs_dly = 2'd0;
        rx_fs_dly = 2'd0;
    endtask

    task automatic t_polarity();
        @(negedge clk);
        sync_inv = 1'b1;
        fsync = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "no start on level change", tx_valid, 0);
        frame(0, 0, 0, "R8");
        @(negedge clk);
        sync_inv = 1'b0;
        fsync = 1'b0;
    endtask

    task automatic t_main_bank();
        wr(0, 32, mk(1, 0, 0, 33, 1, 0, 0));
        wr(0, 33, mk(1, 0, 0, 34, 0, 0, 1));
        @(negedge clk);
        main_bank = 3'd1;
        frame(0, 32, 0, "R5");
        @(negedge clk);
        main_bank = 3'd0;
    endtask

    task automatic t_shadow();
        wr(0, 64, mk(1, 0, 0, 65, 2, 0, 1));
        @(negedge clk);
        shadow_bank = 3'd2;
        shadow_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5", "shadow_active before sync", shadow_active, 0);
        frame(0, 64, 0, "R5");
        chk("R5", "shadow_active after sync", shadow_active, 1);
        @(negedge clk);
        shadow_req = 1'b0;
        frame(0, 0, 0, "R5");
        chk("R5", "shadow_active back", shadow_active, 0);
    endtask

    task automatic t_overrun();
        wr(0, 0, mk(1, 0, 0, 5, 7, 1, 1));
        pulse_sync();
        @(negedge clk);
        chk("R10", "no overrun on clean start", tx_overrun, 0);
        repeat (10) @(negedge clk);
        pulse_sync();
        @(negedge clk);
        chk("R10", "overrun pulse", tx_overrun, 1);
        chk("R10", "restart first", tx_first, 1);
        chk("R10", "restart chan", tx_chan, 5);
        @(negedge clk);
        chk("R10", "overrun single cycle", tx_overrun, 0);
        chk("R10", "no second first", tx_first, 0);
        repeat (80) @(negedge clk);
        chk("R3", "idle after restart", tx_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rx_indep();
        t_loop();
        t_delay();
        t_polarity();
        t_main_bank();
        t_shadow();
        t_overrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule